// File: doc/BRIEF.md
# Segment Limit and Access Checker

This block validates one memory access against the state of a loaded segment before any page translation takes place. For each request it reports whether the access must raise a general-protection fault. It also reports the segment-relative offset that the later translation stages would use. The fault error code is always zero, so no code is produced.

The caller supplies the following state:
- the selector, base, limit and attribute bits of the segment in use;
- the default-size bit of the current code segment;
- a per-access address-size override;
- the virtual address, the access size and the access kind.

Three things are checked:
- A null selector always faults.
- Segments in the data register group enforce their writable and readable bits and may be expand-down. All other segments skip those checks and always use the normal limit test.
- The first and last byte offsets of the access are both compared against the limit. The comparison runs in the direction the segment demands.

The inputs are captured on a valid strobe. The result appears one clock later together with a response valid pulse.

Top module: `seg_chk`

## Requirements
- R1: An access whose selector is all zeros raises gp_fault_o, whatever the other inputs are.
- R2: For a data-group segment (data_seg_i=1), a write (acc_type_i=2'b01) with attr_wr_i=0 raises gp_fault_o.
- R3: For a data-group segment, a read (acc_type_i=2'b00 or 2'b11) with attr_rd_i=0 raises gp_fault_o. An execute (2'b10) or a write is not faulted by attr_rd_i.
- R4: For a segment outside the data group (data_seg_i=0), attr_wr_i, attr_rd_i and attr_xdown_i have no effect on gp_fault_o or offset_o.
- R5: The effective address size is 16 bits when cs_dflt32_i equals addr_ovr_i, and 32 bits otherwise. offset_o is (vaddr_i - seg_base_i) truncated to that size and zero-extended.
- R6: For a normal segment, gp_fault_o is raised if the offset or the end offset exceeds seg_limit_i. The end offset is offset + acc_size_i - 1, computed one bit wider so that a carry past the top of the address range counts as exceeding the limit.
- R7: For an expand-down data segment (attr_xdown_i=1), gp_fault_o is raised if the offset or the end offset is less than or equal to seg_limit_i.
- R8: rsp_valid_o pulses in the cycle after a cycle with req_valid_i=1, and only then. gp_fault_o and offset_o update only on a request and hold their value otherwise.
- R9: After reset, rsp_valid_o, gp_fault_o and offset_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe; inputs are captured when high |
| data_seg_i | input | 1 | Segment belongs to the data register group |
| selector_i | input | 16 | Selector of the segment in use |
| seg_base_i | input | 32 | Segment base address |
| seg_limit_i | input | 32 | Segment limit |
| attr_wr_i | input | 1 | Segment writable |
| attr_rd_i | input | 1 | Segment readable |
| attr_xdown_i | input | 1 | Segment expands down |
| cs_dflt32_i | input | 1 | Code segment default size is 32 bits |
| addr_ovr_i | input | 1 | Address-size override on this access |
| vaddr_i | input | 32 | Virtual address of the first byte |
| acc_size_i | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| acc_type_i | input | 2 | 00 read, 01 write, 10 execute, 11 read |
| rsp_valid_o | output | 1 | Result valid, one cycle after a request |
| gp_fault_o | output | 1 | General-protection fault |
| offset_o | output | 32 | Segment-relative offset of the first byte |

## Verification
The hardest situations to reach from the ports are accesses whose last byte lands exactly at, or one past, the limit. This matters most when the end offset carries past 0xFFFF in 16-bit mode or past 0xFFFFFFFF in 32-bit mode. Uniform random addresses almost never produce these. The random stimulus therefore picks a target offset first, derives the virtual address from the base, and places the limit within a few bytes of that offset most of the time. Directed cases pin the exact carry boundaries for both address sizes and both segment directions.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned SIZE_W = 4;
  localparam int unsigned SEL_W  = 16;
  localparam int unsigned SHORT_W = 16;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_READ2 = 2'b11
  } acc_type_e;
endpackage

// File: rtl/seg_chk_perm.sv
module seg_chk_perm #(
  parameter int unsigned SEL_W = 16
) (
  input  logic [SEL_W-1:0] selector_i,
  input  logic             data_seg_i,
  input  logic             attr_wr_i,
  input  logic             attr_rd_i,
  input  logic             attr_xdown_i,
  input  logic [1:0]       acc_type_i,
  output logic             perm_fault_o,
  output logic             xdown_o
);
  import seg_chk_pkg::*;

  logic null_sel, is_wr, is_ex, wr_bad, rd_bad;

  always_comb begin
    null_sel = (selector_i == '0);
    is_wr    = (acc_type_i == ACC_WRITE);
    is_ex    = (acc_type_i == ACC_EXEC);
    // attribute checks apply to the data register group only
    wr_bad   = data_seg_i && !attr_wr_i && is_wr;
    rd_bad   = data_seg_i && !attr_rd_i && !is_wr && !is_ex;
    perm_fault_o = null_sel || wr_bad || rd_bad;
    xdown_o      = data_seg_i && attr_xdown_i;
  end
endmodule

// File: rtl/seg_chk_offset.sv
module seg_chk_offset #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SIZE_W  = 4,
  parameter int unsigned SHORT_W = 16
) (
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              cs_dflt32_i,
  input  logic              addr_ovr_i,
  output logic [ADDR_W-1:0] offset_o,
  output logic [ADDR_W:0]   end_ofs_o
);
  localparam int unsigned PAD_W = ADDR_W + 1 - SIZE_W;

  logic [ADDR_W-1:0] diff;
  logic              short_mode;

  always_comb begin
    diff       = vaddr_i - base_i;
    short_mode = (cs_dflt32_i == addr_ovr_i);
    offset_o   = short_mode ? {{(ADDR_W-SHORT_W){1'b0}}, diff[SHORT_W-1:0]} : diff;
    // one extra bit keeps the carry past the address range visible
    end_ofs_o  = {1'b0, offset_o} + {{PAD_W{1'b0}}, size_i} - {{ADDR_W{1'b0}}, 1'b1};
  end
endmodule

// File: rtl/seg_chk_limit.sv
module seg_chk_limit #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [ADDR_W:0]   end_ofs_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic              xdown_i,
  output logic              limit_fault_o
);
  logic [ADDR_W:0] lim_w, ofs_w;

  always_comb begin
    lim_w = {1'b0, limit_i};
    ofs_w = {1'b0, offset_i};
    if (xdown_i) limit_fault_o = (ofs_w <= lim_w) || (end_ofs_i <= lim_w);
    else         limit_fault_o = (ofs_w >  lim_w) || (end_ofs_i >  lim_w);
  end
endmodule

// File: rtl/seg_chk.sv
module seg_chk #(
  parameter int unsigned ADDR_W  = seg_chk_pkg::ADDR_W,
  parameter int unsigned SIZE_W  = seg_chk_pkg::SIZE_W,
  parameter int unsigned SEL_W   = seg_chk_pkg::SEL_W,
  parameter int unsigned SHORT_W = seg_chk_pkg::SHORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              data_seg_i,
  input  logic [SEL_W-1:0]  selector_i,
  input  logic [ADDR_W-1:0] seg_base_i,
  input  logic [ADDR_W-1:0] seg_limit_i,
  input  logic              attr_wr_i,
  input  logic              attr_rd_i,
  input  logic              attr_xdown_i,
  input  logic              cs_dflt32_i,
  input  logic              addr_ovr_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [SIZE_W-1:0] acc_size_i,
  input  logic [1:0]        acc_type_i,
  output logic              rsp_valid_o,
  output logic              gp_fault_o,
  output logic [ADDR_W-1:0] offset_o
);
  logic              perm_fault, xdown, limit_fault;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W:0]   end_ofs;

  seg_chk_perm #(.SEL_W(SEL_W)) i_perm (
    .selector_i  (selector_i),
    .data_seg_i  (data_seg_i),
    .attr_wr_i   (attr_wr_i),
    .attr_rd_i   (attr_rd_i),
    .attr_xdown_i(attr_xdown_i),
    .acc_type_i  (acc_type_i),
    .perm_fault_o(perm_fault),
    .xdown_o     (xdown)
  );

  seg_chk_offset #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SHORT_W(SHORT_W)) i_offset (
    .vaddr_i    (vaddr_i),
    .base_i     (seg_base_i),
    .size_i     (acc_size_i),
    .cs_dflt32_i(cs_dflt32_i),
    .addr_ovr_i (addr_ovr_i),
    .offset_o   (offset),
    .end_ofs_o  (end_ofs)
  );

  seg_chk_limit #(.ADDR_W(ADDR_W)) i_limit (
    .offset_i     (offset),
    .end_ofs_i    (end_ofs),
    .limit_i      (seg_limit_i),
    .xdown_i      (xdown),
    .limit_fault_o(limit_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      gp_fault_o  <= 1'b0;
      offset_o    <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        gp_fault_o <= perm_fault || limit_fault;
        offset_o   <= offset;
      end
    end
  end

  AST_NULL_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && selector_i == '0) |=> (rsp_valid_o && gp_fault_o)); // R1

  AST_WR_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && data_seg_i && !attr_wr_i && acc_type_i == 2'b01) |=> gp_fault_o); // R2

  AST_RD_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && data_seg_i && !attr_rd_i && !acc_type_i[0] && !acc_type_i[1]) |=> gp_fault_o); // R3

  AST_SHORT_OFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cs_dflt32_i == addr_ovr_i) |=> (offset_o[ADDR_W-1:SHORT_W] == '0)); // R5

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R8

  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && $stable(offset_o) && $stable(gp_fault_o))); // R8
endmodule

// File: tb/test_seg_chk.sv
`timescale 1ns/1ps
module test_seg_chk;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        data_seg_i = 1'b0;
  logic [15:0] selector_i = '0;
  logic [31:0] seg_base_i = '0, seg_limit_i = '0, vaddr_i = '0;
  logic        attr_wr_i = 1'b0, attr_rd_i = 1'b0, attr_xdown_i = 1'b0;
  logic        cs_dflt32_i = 1'b0, addr_ovr_i = 1'b0;
  logic [3:0]  acc_size_i = 4'd1;
  logic [1:0]  acc_type_i = 2'b00;
  logic        rsp_valid_o, gp_fault_o;
  logic [31:0] offset_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  seg_chk i_seg_chk (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_ofs(input logic [31:0] va, input logic [31:0] b,
                                          input logic d32, input logic ov);
    longint unsigned m = (d32 != ov) ? 64'hFFFF_FFFF : 64'hFFFF;
    return 32'((longint'(va) - longint'(b)) & m);
  endfunction

  function automatic logic ref_fault(input logic [15:0] sel, input logic ds, input logic w,
                                     input logic r, input logic xd, input logic [1:0] t,
                                     input logic [31:0] ofs, input logic [3:0] sz,
                                     input logic [31:0] lim);
    longint unsigned o = ofs, e = longint'(ofs) + sz - 1, l = lim;
    if (sel == 0) return 1'b1;
    if (ds && !w && t == 2'b01) return 1'b1;
    if (ds && !r && (t == 2'b00 || t == 2'b11)) return 1'b1;
    if (ds && xd) return (o <= l) || (e <= l);
    return (o > l) || (e > l);
  endfunction

  // drive one request, check its response, then check the idle hold
  task automatic run(input string req, input logic ds, input logic [15:0] sel,
                     input logic [31:0] b, input logic [31:0] lim, input logic w,
                     input logic r, input logic xd, input logic d32, input logic ov,
                     input logic [31:0] va, input logic [3:0] sz, input logic [1:0] t);
    logic [31:0] eo;
    logic ef;
    @(negedge clk_i);
    req_valid_i = 1; data_seg_i = ds; selector_i = sel; seg_base_i = b; seg_limit_i = lim;
    attr_wr_i = w; attr_rd_i = r; attr_xdown_i = xd; cs_dflt32_i = d32; addr_ovr_i = ov;
    vaddr_i = va; acc_size_i = sz; acc_type_i = t;
    eo = ref_ofs(va, b, d32, ov);
    ef = ref_fault(sel, ds, w, r, xd, t, eo, sz, lim);
    @(negedge clk_i);
    req_valid_i = 0;
    chk({req, " rsp_valid (R8)"}, 64'(rsp_valid_o), 64'd1);
    chk({req, " fault"}, 64'(gp_fault_o), 64'(ef));
    chk({req, " offset"}, 64'(offset_o), 64'(eo));
    // inputs move while idle; outputs must hold
    selector_i = 16'h0; vaddr_i = ~va;
    @(negedge clk_i);
    chk("R8 idle rsp_valid", 64'(rsp_valid_o), 64'd0);
    chk("R8 idle hold", {31'd0, gp_fault_o, offset_o}, {31'd0, ef, eo});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] sizes [4] = '{4'd1, 4'd2, 4'd4, 4'd8};
    void'($urandom(32'h5E6C_0123));
    #1;
    chk("R9 reset rsp_valid", 64'(rsp_valid_o), 64'd0);
    chk("R9 reset fault", 64'(gp_fault_o), 64'd0);
    chk("R9 reset offset", 64'(offset_o), 64'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 null selector, otherwise legal access
    run("R1 null sel", 1, 16'h0, 32'h0, 32'hFFFF_FFFF, 1, 1, 0, 1, 0, 32'h10, 4'd4, 2'b00);
    // R2 write to read-only data segment
    run("R2 wr prot", 1, 16'h10, 32'h0, 32'hFFFF_FFFF, 0, 1, 0, 1, 0, 32'h10, 4'd4, 2'b01);
    // R3 read to exec-only data segment; execute is not faulted
    run("R3 rd prot", 1, 16'h10, 32'h0, 32'hFFFF_FFFF, 1, 0, 0, 1, 0, 32'h10, 4'd4, 2'b00);
    run("R3 rd prot 11", 1, 16'h10, 32'h0, 32'hFFFF_FFFF, 1, 0, 0, 1, 0, 32'h10, 4'd4, 2'b11);
    run("R3 exec ok", 1, 16'h10, 32'h0, 32'hFFFF_FFFF, 1, 0, 0, 1, 0, 32'h10, 4'd4, 2'b10);
    // R4 non-data segment ignores attributes
    run("R4 attrs ignored", 0, 16'h8, 32'h100, 32'hFFF, 0, 0, 1, 1, 0, 32'h200, 4'd4, 2'b01);
    // R5 16-bit wrap of offset
    run("R5 short wrap", 1, 16'h10, 32'h0001_0010, 32'hFFFF, 1, 1, 0, 0, 0, 32'h0000_0008, 4'd1, 2'b00);
    run("R5 ovr 32", 1, 16'h10, 32'h0001_0010, 32'hFFFF_FFFF, 1, 1, 0, 0, 1, 32'h0000_0008, 4'd1, 2'b00);
    // R6 carry past 0xFFFF and past 0xFFFFFFFF
    run("R6 short carry", 1, 16'h10, 32'h0, 32'hFFFF, 1, 1, 0, 1, 1, 32'h0000_FFFF, 4'd2, 2'b00);
    run("R6 full carry", 1, 16'h10, 32'h0, 32'hFFFF_FFFF, 1, 1, 0, 1, 0, 32'hFFFF_FFFF, 4'd4, 2'b00);
    run("R6 end at limit", 1, 16'h10, 32'h0, 32'h1003, 1, 1, 0, 1, 0, 32'h1000, 4'd4, 2'b00);
    run("R6 end past limit", 1, 16'h10, 32'h0, 32'h1002, 1, 1, 0, 1, 0, 32'h1000, 4'd4, 2'b00);
    // R7 expand-down boundaries
    run("R7 xdown ok", 1, 16'h10, 32'h0, 32'h0FFF, 1, 1, 1, 1, 0, 32'h1000, 4'd4, 2'b00);
    run("R7 xdown at limit", 1, 16'h10, 32'h0, 32'h0FFF, 1, 1, 1, 1, 0, 32'h0FFF, 4'd4, 2'b00);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] b, ofs, lim;
      logic d32, ov;
      b = $urandom; ofs = $urandom; d32 = $urandom; ov = $urandom;
      if (d32 == ov) ofs = ofs & 32'hFFFF;
      if ($urandom % 8 == 0) ofs = (d32 == ov) ? 32'hFFFF - ($urandom % 8) : 32'hFFFF_FFFF - ($urandom % 8);
      lim = ($urandom % 4 == 0) ? $urandom : ofs + ($urandom % 16) - 8;
      run("R6/R7 random", 1'($urandom), ($urandom % 16 == 0) ? 16'h0 : 16'($urandom | 1),
          b, lim, 1'($urandom), 1'($urandom), 1'($urandom), d32, ov,
          b + ofs, sizes[$urandom % 4], 2'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule